// File: doc/BRIEF.md
# CPU Clock Stabilization Hold and Even Divider

This block derives the CPU and peripheral clocking from a free-running oscillator clock. It produces single-cycle clock-enable pulses in the oscillator domain rather than derived clocks. After reset, and again on every wakeup request, it keeps both enables off while a stabilization counter runs. The length of that hold depends on whether the selected source is a crystal or an on-chip oscillator. A fixed extra margin, given as a parameter, is added in both cases.

Once the hold has expired, the ready flag rises and the CPU enable is produced at the oscillator rate divided by 2N. N is an 8-bit divisor register that software may rewrite at any moment. When N is 0 the divider is bypassed and the CPU enable is high on every oscillator cycle. A new divisor is adopted only where a CPU clock period ends, so no period is ever cut short. The peripheral enable fires on every second CPU enable pulse, which makes the peripheral clock the CPU clock divided by two.

Top module: `cpu_clk_gen`

## Requirements
- R1: While reset is asserted, `cpu_en`, `per_en` and `clk_ready` are low. Reset clears the divisor to 0 and starts a stabilization hold, so after that hold `cpu_en` is high on every cycle.
- R2: With `src_xtal`=1 (crystal) sampled at the start of a hold, `clk_ready` stays low for exactly XTAL_HOLD+EXTRA_HOLD oscillator cycles. The count starts at the clock edge that samples the wakeup, or at the first edge after reset is released.
- R3: With `src_xtal`=0 (on-chip oscillator) sampled at the start of a hold, the hold lasts exactly ONCHIP_HOLD+EXTRA_HOLD cycles.
- R4: Each wakeup request restarts the hold from zero and resamples `src_xtal`. This applies whether the block is running or already holding. While `clk_ready` is low, `cpu_en` and `per_en` stay low.
- R5: With divisor N from 1 to 255, `cpu_en` is a one-cycle pulse every 2N cycles. The first pulse falls on the 2N-th cycle with `clk_ready` high.
- R6: With N=0, `cpu_en` is high on every cycle in which `clk_ready` is high.
- R7: With N=255, the spacing between `cpu_en` pulses is 510 cycles.
- R8: A divisor written with `div_we`=1 and `div_wdata`=N is adopted at the end of the CPU period in progress. That period completes at its old length.
- R9: `per_en` is high only together with `cpu_en`, on the 2nd, 4th, 6th, ... `cpu_en` pulse counted from the rise of `clk_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_req | input | 1 | Wakeup request; restarts the stabilization hold |
| src_xtal | input | 1 | Source class: 1 crystal, 0 on-chip oscillator |
| div_we | input | 1 | Divisor register write strobe |
| div_wdata | input | DIV_W | Divisor value N to write |
| cpu_en | output | 1 | CPU clock enable pulse |
| per_en | output | 1 | Peripheral clock enable pulse |
| clk_ready | output | 1 | High once the stabilization hold has expired |

## Verification
The bench keeps the full crystal and on-chip hold lengths (992 and 224) and sets the extra margin to 16. The two holds, 1008 and 240 cycles, are therefore told apart exactly. A hold that is off by one cycle, or that uses the wrong source class, shows up as a mismatch. The 8-bit divisor keeps its full width, so the 510-cycle period at N=255 and the bypass at N=0 are both measured. So are divisor switches in both directions across those extremes.

// File: rtl/cgen_pkg.sv
package cgen_pkg;

  typedef enum logic {
    SRC_ONCHIP = 1'b0,
    SRC_XTAL   = 1'b1
  } src_class_e;

  // Total stabilization hold, in oscillator cycles, for a source class.
  function automatic int unsigned hold_cycles(
    input logic        is_xtal,
    input int unsigned xtal_base,
    input int unsigned onchip_base,
    input int unsigned extra
  );
    return (is_xtal ? xtal_base : onchip_base) + extra;
  endfunction

  // CPU enable period, in oscillator cycles, for divisor value n.
  function automatic int unsigned period_len(input int unsigned n);
    return (n == 0) ? 1 : 2 * n;
  endfunction

endpackage

// File: rtl/cgen_stab.sv
module cgen_stab
  import cgen_pkg::*;
#(
  parameter int unsigned XTAL_HOLD   = 992,
  parameter int unsigned ONCHIP_HOLD = 224,
  parameter int unsigned EXTRA_HOLD  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_req,
  input  logic src_xtal,
  output logic ready,
  output logic restart
);

  localparam int unsigned HOLD_MAX =
    ((XTAL_HOLD > ONCHIP_HOLD) ? XTAL_HOLD : ONCHIP_HOLD) + EXTRA_HOLD;
  localparam int CW = (HOLD_MAX < 2) ? 1 : $clog2(HOLD_MAX + 1);

  logic          start_pend;
  logic          cls_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          expire;

  // A pending start after reset behaves like a wakeup request.
  assign restart = start_pend | wake_req;
  assign limit   = CW'(hold_cycles(cls_q, XTAL_HOLD, ONCHIP_HOLD, EXTRA_HOLD) - 1);
  assign expire  = !ready && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_pend <= 1'b1;
      cls_q      <= SRC_XTAL;
      cnt        <= '0;
      ready      <= 1'b0;
    end else if (restart) begin
      start_pend <= 1'b0;
      cls_q      <= src_xtal;
      cnt        <= '0;
      ready      <= 1'b0;
    end else if (expire) begin
      ready      <= 1'b1;
    end else if (!ready) begin
      cnt        <= cnt + 1'b1;
    end
  end

  assert_count_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> cnt <= limit);

  assert_restart_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !ready);

  assert_ready_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !wake_req) |=> ready);

  assert_class_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> $stable(cls_q));

endmodule

// File: rtl/cgen_divreg.sv
module cgen_divreg #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [DIV_W-1:0] wdata,
  input  logic             ready,
  input  logic             boundary,
  output logic [DIV_W-1:0] n_act
);

  logic [DIV_W-1:0] sw_div;
  logic [DIV_W-1:0] n_next;
  logic             adopt;

  assign n_next = we ? wdata : sw_div;
  // The active divisor changes only while held or where a period ends.
  assign adopt  = !ready || boundary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_div <= '0;
      n_act  <= '0;
    end else begin
      if (we)    sw_div <= wdata;
      if (adopt) n_act  <= n_next;
    end
  end

  assert_switch_on_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !boundary) |=> $stable(n_act));

endmodule

// File: rtl/cgen_div.sv
module cgen_div
  import cgen_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready,
  input  logic [DIV_W-1:0] n_act,
  output logic             cpu_en
);

  localparam int CNTW = DIV_W + 1;

  logic [CNTW-1:0] cnt;
  logic [CNTW-1:0] last;

  assign last   = CNTW'(period_len(32'(n_act)) - 1);
  assign cpu_en = ready && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!ready || cpu_en) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  assert_cnt_in_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> cnt <= last);

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_en ##1 (ready && n_act != '0) |-> !cpu_en);

  assert_bypass_every_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && n_act == '0) |-> cpu_en);

endmodule

// File: rtl/cgen_half.sv
module cgen_half (
  input  logic clk,
  input  logic rst_n,
  input  logic ready,
  input  logic cpu_en,
  output logic per_en
);

  logic tog;

  assign per_en = cpu_en && tog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tog <= 1'b0;
    else if (!ready) tog <= 1'b0;
    else if (cpu_en) tog <= ~tog;
  end

  assert_per_inside_cpu_R9: assert property (@(posedge clk) disable iff (!rst_n)
    per_en |-> cpu_en);

  assert_per_alternates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en && ready && !per_en) |=> (!cpu_en || !ready || per_en));

endmodule

// File: rtl/cpu_clk_gen.sv
module cpu_clk_gen #(
  parameter int unsigned XTAL_HOLD   = 992,
  parameter int unsigned ONCHIP_HOLD = 224,
  parameter int unsigned EXTRA_HOLD  = 64,
  parameter int          DIV_W       = 8
) (
  input  logic             osc_clk,
  input  logic             rst_n,
  input  logic             wake_req,
  input  logic             src_xtal,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  output logic             cpu_en,
  output logic             per_en,
  output logic             clk_ready
);

  logic             stab_ready;
  logic             stab_restart;
  logic [DIV_W-1:0] n_act;
  logic             cpu_pulse;
  logic             per_pulse;

  cgen_stab #(
    .XTAL_HOLD  (XTAL_HOLD),
    .ONCHIP_HOLD(ONCHIP_HOLD),
    .EXTRA_HOLD (EXTRA_HOLD)
  ) u_stab (
    .clk     (osc_clk),
    .rst_n   (rst_n),
    .wake_req(wake_req),
    .src_xtal(src_xtal),
    .ready   (stab_ready),
    .restart (stab_restart)
  );

  cgen_divreg #(.DIV_W(DIV_W)) u_divreg (
    .clk     (osc_clk),
    .rst_n   (rst_n),
    .we      (div_we),
    .wdata   (div_wdata),
    .ready   (stab_ready),
    .boundary(cpu_pulse),
    .n_act   (n_act)
  );

  cgen_div #(.DIV_W(DIV_W)) u_div (
    .clk   (osc_clk),
    .rst_n (rst_n),
    .ready (stab_ready),
    .n_act (n_act),
    .cpu_en(cpu_pulse)
  );

  cgen_half u_half (
    .clk   (osc_clk),
    .rst_n (rst_n),
    .ready (stab_ready),
    .cpu_en(cpu_pulse),
    .per_en(per_pulse)
  );

  assign cpu_en    = cpu_pulse;
  assign per_en    = per_pulse;
  assign clk_ready = stab_ready;

  assert_enables_gated_R4: assert property (@(posedge osc_clk) disable iff (!rst_n)
    !clk_ready |-> (!cpu_en && !per_en));

  assert_restart_holds_R4: assert property (@(posedge osc_clk) disable iff (!rst_n)
    stab_restart |=> !cpu_en);

endmodule

// File: tb/tb_cpu_clk_gen.sv
module tb_cpu_clk_gen;

  localparam int unsigned XH = 992;
  localparam int unsigned OH = 224;
  localparam int unsigned EH = 16;
  localparam int          DW = 8;
  localparam int          H_XTAL   = XH + EH;
  localparam int          H_ONCHIP = OH + EH;

  logic          osc_clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wake_req = 1'b0;
  logic          src_xtal = 1'b1;
  logic          div_we = 1'b0;
  logic [DW-1:0] div_wdata = '0;
  logic          cpu_en, per_en, clk_ready;

  cpu_clk_gen #(
    .XTAL_HOLD(XH), .ONCHIP_HOLD(OH), .EXTRA_HOLD(EH), .DIV_W(DW)
  ) dut (
    .osc_clk(osc_clk), .rst_n(rst_n), .wake_req(wake_req), .src_xtal(src_xtal),
    .div_we(div_we), .div_wdata(div_wdata),
    .cpu_en(cpu_en), .per_en(per_en), .clk_ready(clk_ready)
  );

  always #4 osc_clk = ~osc_clk;  // 125 MHz

  int    n_tests = 0;
  int    n_fail  = 0;
  int    cyc     = 0;
  int    gate_err = 0;
  int    exp_q[$];
  string tag_q[$];
  bit    done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int gap_of(input int n);
    return (n == 0) ? 1 : n + n;
  endfunction

  task automatic push(input int gap, input string tag);
    exp_q.push_back(gap);
    tag_q.push_back(tag);
  endtask

  always @(posedge osc_clk) cyc <= cyc + 1;

  // Monitor: measures spacing of CPU pulses and pops expected items.
  int last_cyc = 0;
  int pidx = 0;
  bit prev_ready = 0;
  always @(negedge osc_clk) begin
    if (!rst_n) begin
      prev_ready = 0;
    end else begin
      if (!clk_ready && (cpu_en || per_en)) gate_err++;
      if (clk_ready && !prev_ready) begin
        last_cyc = cyc - 1;
        pidx = 0;
      end
      if (clk_ready && cpu_en) begin
        int gap, e;
        string t;
        gap = cyc - last_cyc;
        last_cyc = cyc;
        pidx++;
        if (exp_q.size() > 0) begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(gap == e, t, gap, e);
        end
        check(per_en == (pidx % 2 == 0), "R9 per_en on even pulse", int'(per_en), int'(pidx % 2 == 0));
      end else if (per_en) begin
        check(1'b0, "R9 per_en without cpu_en", 1, 0);
      end
      prev_ready = clk_ready;
    end
  end

  task automatic measure_hold(output int n);
    n = 0;
    while (n < 5000) begin
      @(negedge osc_clk); #1;
      wake_req = 1'b0;
      if (clk_ready) break;
      n++;
    end
  endtask

  task automatic do_wake(input logic src, input int exp_h, input string tag);
    int h;
    @(negedge osc_clk); #1;
    src_xtal = src;
    wake_req = 1'b1;
    measure_hold(h);
    check(h == exp_h, tag, h, exp_h);
    check(gate_err == 0, "R4 enables low during hold", gate_err, 0);
  endtask

  task automatic wait_drain(input string tag);
    int g = 0;
    while (exp_q.size() > 0 && g < 4000) begin
      @(negedge osc_clk);
      g++;
    end
    #1;
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic set_div(input int nnew, input int nold, input int k, input string tag);
    do begin
      @(negedge osc_clk); #1;
    end while (!cpu_en);
    @(negedge osc_clk); #1;
    div_we = 1'b1;
    div_wdata = DW'(nnew);
    if (nold != 0) push(gap_of(nold), "R8 old period completes");
    for (int i = 0; i < k; i++) push(gap_of(nnew), tag);
    @(negedge osc_clk); #1;
    div_we = 1'b0;
    wait_drain({tag, " drained"});
  endtask

  task automatic do_reset(input logic src);
    int h;
    exp_q.delete();
    tag_q.delete();
    @(negedge osc_clk); #1;
    rst_n = 1'b0;
    src_xtal = src;
    repeat (3) @(negedge osc_clk);
    #1;
    check(!cpu_en && !per_en && !clk_ready, "R1 outputs low in reset",
          int'({cpu_en, per_en, clk_ready}), 0);
    for (int i = 0; i < 4; i++) push(1, "R1 divisor cleared, pulse every cycle");
    rst_n = 1'b1;
    measure_hold(h);
    check(h == (src ? H_XTAL : H_ONCHIP), "R2 hold after reset", h, src ? H_XTAL : H_ONCHIP);
    wait_drain("R1 drained");
  endtask

  initial begin
    repeat (2000000) @(posedge osc_clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);                               // R1, R2
    set_div(3, 0, 5, "R5 N=3 period 6");
    set_div(1, 3, 5, "R5 N=1 period 2");
    set_div(255, 1, 3, "R7 N=255 period 510");
    set_div(0, 255, 5, "R6 N=0 every cycle");
    set_div(2, 0, 4, "R5 N=2 period 4");

    // R3: running block woken with on-chip class; divisor retained.
    do_wake(1'b0, H_ONCHIP, "R3 on-chip hold");
    for (int i = 0; i < 3; i++) push(4, "R5 first pulses after wake");
    wait_drain("R5 after wake drained");

    // R4: restart inside a hold, class resampled on the second request.
    @(negedge osc_clk); #1;
    src_xtal = 1'b1;
    wake_req = 1'b1;
    @(negedge osc_clk); #1;
    wake_req = 1'b0;
    begin
      int early = 0;
      for (int i = 0; i < 99; i++) begin
        @(negedge osc_clk); #1;
        if (clk_ready) early++;
      end
      check(early == 0, "R4 ready low during interrupted hold", early, 0);
    end
    do_wake(1'b0, H_ONCHIP, "R4 restarted hold uses new class");

    // R2 via wakeup with crystal class.
    do_wake(1'b1, H_XTAL, "R2 crystal hold after wake");
    for (int i = 0; i < 2; i++) push(4, "R5 first pulses after crystal wake");
    wait_drain("R5 drained");

    // R1: reset mid-run clears divisor back to bypass.
    do_reset(1'b0);

    check(gate_err == 0, "R4 no enable while not ready", gate_err, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule